// File: doc/BRIEF.md
# Two-Phase Configuration Register Write Port

This block lets a host load a small bank of configuration registers over one shared 10-bit bus. The host's own strobe clock drives it. Each register write uses two consecutive bus words. The first word carries the register address and the second carries the value. A 2-bit tag in the top bits of the bus tells the two phases apart. The register contents are always visible on a flat parallel output, so downstream logic can use them directly.

The port accepts words only when it is selected for control traffic, meaning the mode input and the read/write input are both low. When the mode input is high, the bus belongs to a different consumer and this block ignores it. A word whose tag does not fit the current phase is dropped and flagged with a one-cycle error pulse. An address beyond the implemented bank is dropped silently. If the port stops being selected in the middle of a write, the half-finished write is abandoned.

Top module: `cfg_wport`

## Requirements
- R1: A synchronous active-high reset clears every register to 0, clears `tag_err`, and puts the port in the address phase.
- R2: When `anc_sel`=0 and `rd_wr`=0, a word with `bus[9:8]`=2'b00 in the address phase records `bus[7:0]` as the target address. The next selected word, which carries `bus[9:8]`=2'b11, writes `bus[7:0]` into that register. The new value appears on `regs_o` after the rising edge that samples the data word.
- R3: Register i occupies `regs_o[8*i+7:8*i]`. The word pair 0x00D then 0x327 sets register 13 to 0x27 and changes no other register.
- R4: In the address phase, a selected word whose tag is not 2'b00 writes nothing. It raises `tag_err` for the single cycle after its sampling edge, and the port stays in the address phase.
- R5: In the data phase, a selected word whose tag is not 2'b11 writes nothing. It raises `tag_err` for one cycle and returns the port to the address phase.
- R6: A complete write to an address of 32 or more changes no register and raises no `tag_err`.
- R7: If `anc_sel` or `rd_wr` is high on any edge between the address word and the data word, the pending address is dropped. The next selected word is then treated as an address word.
- R8: On an edge where `anc_sel` or `rd_wr` is high, no register changes and `tag_err` stays low for the following cycle.
- R9: Writes may follow one another with no idle cycle between them. Each pair of words completes one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host strobe clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| anc_sel | input | 1 | Mode select: 1 routes the bus elsewhere, 0 selects control writes |
| rd_wr | input | 1 | Direction: 0 means write |
| bus | input | 10 | Shared word: tag in [9:8], address or data in [7:0] |
| regs_o | output | 256 | All 32 registers, register i at bits [8i+7:8i] |
| tag_err | output | 1 | One-cycle pulse for a word whose tag does not fit the phase |

## Verification
The bench drives correct address/data pairs, including the test-pattern example and back-to-back writes to neighbouring registers. These show whether the address and the value land in the right byte lane and whether one write leaks into the next. It then sends each of the wrong tags in each phase, separating an error that keeps the port in the address phase from one that forces it back there. Pairs aimed past the end of the bank, and deselecting the port through either select input between the two phases, show whether a dropped address or an idle edge leaves the bank untouched.

// File: rtl/cfg_wport.sv
module cfg_wport #(
  parameter int NREGS  = 32,
  parameter int REG_W  = 8,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     anc_sel,
  input  logic                     rd_wr,
  input  logic [((ADDR_W > REG_W) ? ADDR_W : REG_W)+1:0] bus,
  output logic [NREGS*REG_W-1:0]   regs_o,
  output logic                     tag_err
);
  localparam int PAY_W = (ADDR_W > REG_W) ? ADDR_W : REG_W;
  localparam logic [1:0] TAG_ADDR = 2'b00;
  localparam logic [1:0] TAG_DATA = 2'b11;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NREGS);

  logic              phase_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        tag;
  logic              active, take_addr, take_data, bad_tag, in_range;

  assign tag       = bus[PAY_W+1:PAY_W];
  assign active    = !anc_sel && !rd_wr;
  assign take_addr = active && !phase_q && (tag == TAG_ADDR);
  assign take_data = active &&  phase_q && (tag == TAG_DATA);
  assign bad_tag   = active && !take_addr && !take_data;
  assign in_range  = {1'b0, addr_q} < LIMIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      addr_q  <= '0;
      tag_err <= 1'b0;
    end else begin
      tag_err <= bad_tag;
      if (take_addr) begin
        addr_q  <= bus[ADDR_W-1:0];
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (take_data && in_range && addr_q == ADDR_W'(i))
        q <= bus[REG_W-1:0];
    end
    assign regs_o[i*REG_W +: REG_W] = q;
  end
endmodule

module cfg_wport_chk #(
  parameter int NREGS  = 32,
  parameter int REG_W  = 8,
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 10
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   anc_sel,
  input logic                   rd_wr,
  input logic [BUS_W-1:0]       bus,
  input logic [NREGS*REG_W-1:0] regs_o,
  input logic                   tag_err,
  input logic                   phase_q,
  input logic [ADDR_W-1:0]      addr_q
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (regs_o == '0 && !tag_err && !phase_q));

  p_write_needs_data_tag_r2: assert property (@(posedge clk) disable iff (rst)
    !(!anc_sel && !rd_wr && phase_q && bus[BUS_W-1:BUS_W-2] == 2'b11) |=> $stable(regs_o));

  p_err_stays_addr_r4: assert property (@(posedge clk) disable iff (rst)
    (!anc_sel && !rd_wr && !phase_q && bus[BUS_W-1:BUS_W-2] != 2'b00) |=> (tag_err && !phase_q));

  p_err_leaves_data_r5: assert property (@(posedge clk) disable iff (rst)
    (!anc_sel && !rd_wr && phase_q && bus[BUS_W-1:BUS_W-2] != 2'b11) |=> (tag_err && !phase_q));

  p_no_oob_write_r6: assert property (@(posedge clk) disable iff (rst)
    (phase_q && {1'b0, addr_q} >= (ADDR_W+1)'(NREGS)) |=> $stable(regs_o));

  p_deselect_drops_r7: assert property (@(posedge clk) disable iff (rst)
    (anc_sel || rd_wr) |=> !phase_q);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (anc_sel || rd_wr) |=> ($stable(regs_o) && !tag_err));
endmodule

bind cfg_wport cfg_wport_chk #(
  .NREGS(NREGS), .REG_W(REG_W), .ADDR_W(ADDR_W), .BUS_W(PAY_W+2)
) chk_i (
  .clk(clk), .rst(rst), .anc_sel(anc_sel), .rd_wr(rd_wr), .bus(bus),
  .regs_o(regs_o), .tag_err(tag_err), .phase_q(phase_q), .addr_q(addr_q)
);

// File: tb/cfg_wport_tb.sv
module cfg_wport_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         anc_sel = 1'b0;
  logic         rd_wr = 1'b1;
  logic [9:0]   bus = '0;
  logic [255:0] regs_o;
  logic         tag_err;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] exp_r [32];

  always #5 clk = ~clk;

  cfg_wport dut_i (.clk(clk), .rst(rst), .anc_sel(anc_sel), .rd_wr(rd_wr),
                   .bus(bus), .regs_o(regs_o), .tag_err(tag_err));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_bank(input string req);
    bit ok = 1'b1;
    int bad = 0;
    for (int i = 0; i < 32; i++)
      if (regs_o[i*8 +: 8] !== exp_r[i]) begin ok = 1'b0; bad = i; end
    check(ok, req, {24'd0, regs_o[bad*8 +: 8]}, {24'd0, exp_r[bad]});
  endtask

  task automatic word(input logic s, input logic w, input logic [9:0] b);
    anc_sel = s; rd_wr = w; bus = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 32; i++) exp_r[i] = 8'h00;
    check_bank("R1 bank");
    check(tag_err === 1'b0, "R1 tag_err", {31'd0, tag_err}, 0);
  endtask

  task automatic t_example;
    word(0, 0, 10'h00D);
    check(tag_err === 1'b0, "R2 no err on address", {31'd0, tag_err}, 0);
    word(0, 0, 10'h327);
    exp_r[13] = 8'h27;
    check(regs_o[13*8 +: 8] === 8'h27, "R3 reg13", {24'd0, regs_o[13*8 +: 8]}, 32'h27);
    check_bank("R3 others unchanged");
  endtask

  task automatic t_back_to_back;
    word(0, 0, 10'h000); word(0, 0, 10'h3A5);
    word(0, 0, 10'h01F); word(0, 0, 10'h35A);
    word(0, 0, 10'h001); word(0, 0, 10'h3FF);
    exp_r[0] = 8'hA5; exp_r[31] = 8'h5A; exp_r[1] = 8'hFF;
    check_bank("R9 back-to-back");
    check(regs_o[31*8 +: 8] === 8'h5A, "R2 top register", {24'd0, regs_o[31*8 +: 8]}, 32'h5A);
  endtask

  task automatic t_bad_addr_tag;
    word(0, 0, 10'h105);
    check(tag_err === 1'b1, "R4 err on 01 tag", {31'd0, tag_err}, 1);
    word(0, 0, 10'h305);
    check(tag_err === 1'b1, "R4 err on 11 tag in address phase", {31'd0, tag_err}, 1);
    check_bank("R4 no write");
    word(0, 0, 10'h004);
    check(tag_err === 1'b0, "R4 err lasts one cycle", {31'd0, tag_err}, 0);
    word(0, 0, 10'h344);
    exp_r[4] = 8'h44;
    check_bank("R4 port still in address phase");
  endtask

  task automatic t_bad_data_tag;
    word(0, 0, 10'h006);
    word(0, 0, 10'h266);
    check(tag_err === 1'b1, "R5 err on 10 tag", {31'd0, tag_err}, 1);
    check_bank("R5 no write");
    word(0, 0, 10'h377);
    check(tag_err === 1'b1, "R5 returned to address phase", {31'd0, tag_err}, 1);
    check_bank("R5 stray data word ignored");
  endtask

  task automatic t_out_of_range;
    word(0, 0, 10'h020); word(0, 0, 10'h399);
    check(tag_err === 1'b0, "R6 no err", {31'd0, tag_err}, 0);
    word(0, 0, 10'h0FF); word(0, 0, 10'h3EE);
    check_bank("R6 bank untouched");
  endtask

  task automatic t_abandon;
    word(0, 0, 10'h008); word(1, 0, 10'h388); word(0, 0, 10'h388);
    check(tag_err === 1'b1, "R7 mode high drops address", {31'd0, tag_err}, 1);
    check_bank("R7 mode high no write");
    word(0, 0, 10'h009); word(0, 1, 10'h399); word(0, 0, 10'h399);
    check(tag_err === 1'b1, "R7 rd_wr high drops address", {31'd0, tag_err}, 1);
    check_bank("R7 rd_wr high no write");
  endtask

  task automatic t_idle;
    word(1, 0, 10'h2AB);
    check(tag_err === 1'b0, "R8 no err when mode high", {31'd0, tag_err}, 0);
    word(0, 1, 10'h1CD);
    check(tag_err === 1'b0, "R8 no err when rd_wr high", {31'd0, tag_err}, 0);
    word(1, 1, 10'h3FF);
    check_bank("R8 idle no change");
  endtask

  task automatic t_reset_again;
    word(0, 0, 10'h00C);
    rst = 1'b1;
    word(0, 0, 10'h3C3);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) exp_r[i] = 8'h00;
    check_bank("R1 reset clears bank");
    word(0, 0, 10'h3C3);
    check(tag_err === 1'b1, "R1 reset returns to address phase", {31'd0, tag_err}, 1);
    check_bank("R1 no write after reset");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_example();
    t_back_to_back();
    t_bad_addr_tag();
    t_bad_data_tag();
    t_out_of_range();
    t_abandon();
    t_idle();
    t_reset_again();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule